// File: doc/BRIEF.md
# Bundle-Indexed Program Counter Sequencer

This block holds the program counter of a front end whose instructions are packed into fixed-size bundles. The counter is not a byte address. It is a pair: a bundle number and the slot of the instruction inside that bundle. Each bundle carries its own last-slot value, so the number of instructions per bundle varies. The sequencer uses that value to decide when to leave a bundle.

On an advance request the slot moves up by one. From the last slot of the current bundle, the bundle number increments instead and the slot returns to 0. A branch supplies a target bundle, a target slot and that target bundle's last-slot value. A slot past the last one is rejected: the counter keeps its value and a one-cycle illegal-target flag is raised.

The slot field is 3 bits wide for 128-bit bundles and 4 bits wide for 256-bit bundles, chosen by a parameter. A stall input freezes the counter. Fetching and prediction sit outside this block.

Top module: `bundle_pc_seq`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted, the PC reads bundle 0, slot 0 and the illegal flag reads 0.
- R2: In a cycle with the stall input high, the PC keeps its value whatever the advance and branch inputs carry, and the illegal flag is 0 in the following cycle.
- R3: An advance with no branch and no stall, while the current slot is below the current bundle's last-slot value, raises the slot by one and keeps the bundle.
- R4: An advance with no branch and no stall, while the current slot is equal to or above the current bundle's last-slot value, raises the bundle by one and sets the slot to 0. This also holds for a bundle whose last-slot value is 0.
- R5: A branch whose target slot is greater than the target bundle's last-slot value leaves the PC unchanged and sets the illegal flag for exactly the following cycle.
- R6: A branch whose target slot is at most the target bundle's last-slot value loads the target bundle and slot into the PC at the next clock edge.
- R7: When a branch and an advance arrive in the same cycle, the branch alone decides the next PC, for both a legal and an illegal target.
- R8: With no advance, no branch and no stall, the PC holds and the illegal flag is 0 in the following cycle.
- R9: The bundle number wraps from its all-ones value to 0 on a bundle-ending advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall_i | input | 1 | Freeze the PC this cycle |
| adv_i | input | 1 | Step to the next instruction |
| br_valid_i | input | 1 | Branch request this cycle |
| br_bundle_i | input | BUNDLE_W | Branch target bundle number |
| br_slot_i | input | IDX_W | Branch target slot |
| br_last_i | input | IDX_W | Last-slot value of the target bundle |
| cur_last_i | input | IDX_W | Last-slot value of the current bundle |
| pc_bundle_o | output | BUNDLE_W | Current bundle number |
| pc_slot_o | output | IDX_W | Current slot within the bundle |
| illegal_o | output | 1 | Previous cycle's branch target was out of range |

## Verification
A branch and an advance can fall in the same cycle, and so can a stall and either of them. The vector table drives these overlaps directly. It sets the advance high together with a legal branch, together with an illegal branch, and with stall over both. It then checks that only the highest-priority request shaped the PC and the illegal flag one edge later. The expected PC in each of these rows differs from what the losing request would have produced, so a wrong priority shows up at the ports.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2
  } pc_sel_e;

  // Slot field width from bundle size in bits.
  function automatic int slot_bits(input int bundle_bits);
    return (bundle_bits >= 256) ? 4 : 3;
  endfunction

endpackage

// File: rtl/bpc_step.sv
module bpc_step #(
  parameter int BUNDLE_W = 16,
  parameter int IDX_W    = 3
) (
  input  logic [BUNDLE_W-1:0] bundle_i,
  input  logic [IDX_W-1:0]    slot_i,
  input  logic [IDX_W-1:0]    last_i,
  output logic [BUNDLE_W-1:0] nxt_bundle_o,
  output logic [IDX_W-1:0]    nxt_slot_o
);
  logic at_end;

  // R4: at or beyond the last slot leaves the bundle
  assign at_end = (slot_i >= last_i);

  always_comb begin
    if (at_end) begin
      nxt_bundle_o = bundle_i + 1'b1;  // R9: modulo wrap
      nxt_slot_o   = '0;
    end else begin
      nxt_bundle_o = bundle_i;
      nxt_slot_o   = slot_i + 1'b1;    // R3
    end
  end
endmodule

// File: rtl/bpc_tgt_chk.sv
module bpc_tgt_chk #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] slot_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             ok_o
);
  // R5/R6: a slot may equal the last slot but not exceed it
  assign ok_o = (slot_i <= last_i);
endmodule

// File: rtl/bundle_pc_seq.sv
module bundle_pc_seq
  import bpc_pkg::*;
#(
  parameter int  BUNDLE_BITS = 128,
  parameter int  BUNDLE_W    = 16,
  localparam int IDX_W       = slot_bits(BUNDLE_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall_i,
  input  logic                adv_i,
  input  logic                br_valid_i,
  input  logic [BUNDLE_W-1:0] br_bundle_i,
  input  logic [IDX_W-1:0]    br_slot_i,
  input  logic [IDX_W-1:0]    br_last_i,
  input  logic [IDX_W-1:0]    cur_last_i,
  output logic [BUNDLE_W-1:0] pc_bundle_o,
  output logic [IDX_W-1:0]    pc_slot_o,
  output logic                illegal_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [BUNDLE_W-1:0] pc_bundle_q, pc_bundle_d, step_bundle;
  logic [IDX_W-1:0]    pc_slot_q, pc_slot_d, step_slot;
  logic                ill_q, ill_d, tgt_ok, pc_en;
  pc_sel_e             sel;

  bpc_step #(.BUNDLE_W(BUNDLE_W), .IDX_W(IDX_W)) u_step (
    .bundle_i     (pc_bundle_q),
    .slot_i       (pc_slot_q),
    .last_i       (cur_last_i),
    .nxt_bundle_o (step_bundle),
    .nxt_slot_o   (step_slot)
  );

  bpc_tgt_chk #(.IDX_W(IDX_W)) u_chk (
    .slot_i (br_slot_i),
    .last_i (br_last_i),
    .ok_o   (tgt_ok)
  );

  // Priority: stall, then branch, then advance (R2, R7)
  always_comb begin
    sel = PC_HOLD;
    if (!stall_i) begin
      if (br_valid_i)  sel = tgt_ok ? PC_JUMP : PC_HOLD;
      else if (adv_i)  sel = PC_STEP;
    end
  end

  always_comb begin
    pc_bundle_d = pc_bundle_q;
    pc_slot_d   = pc_slot_q;
    unique case (sel)
      PC_STEP: begin pc_bundle_d = step_bundle; pc_slot_d = step_slot; end
      PC_JUMP: begin pc_bundle_d = br_bundle_i; pc_slot_d = br_slot_i; end
      default: ;
    endcase
  end

  assign pc_en = (sel != PC_HOLD);
  assign ill_d = !stall_i && br_valid_i && !tgt_ok;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_bundle_q <= '0;
      pc_slot_q   <= '0;
    end else if (pc_en) begin
      pc_bundle_q <= pc_bundle_d;
      pc_slot_q   <= pc_slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ill_q <= 1'b0;
    else          ill_q <= ill_d;
  end

  assign pc_bundle_o = pc_bundle_q;
  assign pc_slot_o   = pc_slot_q;
  assign illegal_o   = ill_q;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    stall_i |=> ($stable(pc_bundle_q) && $stable(pc_slot_q) && !ill_q));

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall_i && !br_valid_i && adv_i && (pc_slot_q < cur_last_i))
    |=> (pc_slot_q == $past(pc_slot_q) + 1'b1) && $stable(pc_bundle_q));

  // R4
  bundle_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall_i && !br_valid_i && adv_i && (pc_slot_q >= cur_last_i))
    |=> (pc_slot_q == '0) && (pc_bundle_q == $past(pc_bundle_q) + 1'b1));

  // R5
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_o |-> ($stable(pc_bundle_q) && $stable(pc_slot_q)));

  // R6
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall_i && br_valid_i && (br_slot_i <= br_last_i))
    |=> (pc_bundle_q == $past(br_bundle_i)) && (pc_slot_q == $past(br_slot_i)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall_i && !br_valid_i && !adv_i)
    |=> ($stable(pc_bundle_q) && $stable(pc_slot_q) && !ill_q));
endmodule

// File: tb/bundle_pc_seq_bench.sv
module bundle_pc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall_i, adv_i, br_valid_i;
  logic [BW-1:0] br_bundle_i;
  logic [IW-1:0] br_slot_i, br_last_i, cur_last_i;
  logic [BW-1:0] pc_bundle_o;
  logic [IW-1:0] pc_slot_o;
  logic          illegal_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_pc_seq #(.BUNDLE_BITS(128), .BUNDLE_W(BW)) u_bundle_pc_seq (
    .clk, .rst_n, .stall_i, .adv_i, .br_valid_i, .br_bundle_i,
    .br_slot_i, .br_last_i, .cur_last_i, .pc_bundle_o, .pc_slot_o, .illegal_o
  );

  typedef struct packed {
    logic          st, ad, br;
    logic [BW-1:0] tb;
    logic [IW-1:0] ts, tl, cl;
    logic [BW-1:0] eb;
    logic [IW-1:0] es;
    logic          eill;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 15;
  // st ad br  tgt_bundle tgt_slot tgt_last cur_last  exp_bundle exp_slot exp_ill req
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd2, 16'd0, 3'd1,1'b0,4'd3},  // R3
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd2, 16'd0, 3'd2,1'b0,4'd3},  // R3
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd2, 16'd1, 3'd0,1'b0,4'd4},  // R4
    '{1'b1,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd2, 16'd1, 3'd0,1'b0,4'd2},  // R2
    '{1'b1,1'b0,1'b1, 16'd5, 3'd1,3'd3,3'd2, 16'd1, 3'd0,1'b0,4'd2},  // R2
    '{1'b0,1'b0,1'b0, 16'd5, 3'd1,3'd3,3'd2, 16'd1, 3'd0,1'b0,4'd8},  // R8
    '{1'b0,1'b0,1'b1, 16'd5, 3'd3,3'd3,3'd2, 16'd5, 3'd3,1'b0,4'd6},  // R6 slot == last
    '{1'b0,1'b1,1'b1, 16'd9, 3'd0,3'd0,3'd7, 16'd9, 3'd0,1'b0,4'd7},  // R7 legal
    '{1'b0,1'b1,1'b1, 16'd2, 3'd4,3'd3,3'd7, 16'd9, 3'd0,1'b1,4'd7},  // R7/R5 illegal
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd0, 16'd10,3'd0,1'b0,4'd4},  // R4 single slot
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd7, 16'd10,3'd1,1'b0,4'd3},  // R3
    '{1'b0,1'b0,1'b1, 16'd3, 3'd7,3'd7,3'd7, 16'd3, 3'd7,1'b0,4'd6},  // R6
    '{1'b0,1'b1,1'b0, 16'd0, 3'd0,3'd0,3'd7, 16'd4, 3'd0,1'b0,4'd4},  // R4
    '{1'b0,1'b0,1'b1, 16'd0, 3'd7,3'd6,3'd7, 16'd4, 3'd0,1'b1,4'd5},  // R5
    '{1'b1,1'b0,1'b1, 16'd0, 3'd7,3'd0,3'd7, 16'd4, 3'd0,1'b0,4'd2}   // R2 stall masks flag
  };

  task automatic check(input string tag, input logic [BW-1:0] eb,
                       input logic [IW-1:0] es, input logic eill);
    checks++;
    if (pc_bundle_o !== eb || pc_slot_o !== es || illegal_o !== eill) begin
      errors++;
      $display("FAIL %s: got bundle=%0d slot=%0d ill=%0b expected bundle=%0d slot=%0d ill=%0b",
               tag, pc_bundle_o, pc_slot_o, illegal_o, eb, es, eill);
    end
  endtask

  task automatic drive(input logic st, input logic ad, input logic br,
                       input logic [BW-1:0] tb, input logic [IW-1:0] ts,
                       input logic [IW-1:0] tl, input logic [IW-1:0] cl);
    @(negedge clk);
    stall_i = st; adv_i = ad; br_valid_i = br;
    br_bundle_i = tb; br_slot_i = ts; br_last_i = tl; cur_last_i = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", '0, '0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after release", '0, '0, 1'b0);
  endtask

  initial begin
    stall_i = 0; adv_i = 0; br_valid_i = 0;
    br_bundle_i = '0; br_slot_i = '0; br_last_i = '0; cur_last_i = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].st, TBL[i].ad, TBL[i].br, TBL[i].tb, TBL[i].ts, TBL[i].tl, TBL[i].cl);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].eb, TBL[i].es, TBL[i].eill);
    end

    // R5: flag lasts one cycle only
    drive(0, 0, 0, '0, '0, '0, 3'd7);
    check("R5 flag clears", 16'd4, 3'd0, 1'b0);

    // R9: bundle number wraps to zero
    drive(0, 0, 1, 16'hFFFF, 3'd1, 3'd1, 3'd1);
    check("R9 jump to top bundle", 16'hFFFF, 3'd1, 1'b0);
    drive(0, 1, 0, '0, '0, '0, 3'd1);
    check("R9 bundle wrap", 16'd0, 3'd0, 1'b0);

    // R1: asynchronous assertion mid-run
    drive(0, 1, 0, '0, '0, '0, 3'd7);
    check("R3 before reset", 16'd0, 3'd1, 1'b0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 async assert", '0, '0, 1'b0);
    stall_i = 0; adv_i = 0; br_valid_i = 0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 held after release", '0, '0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule